// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a three-phase integrating analog-to-digital converter. It divides the oscillator clock into count ticks and owns a position counter that runs through one fixed measurement cycle. Within that cycle it runs three phases in turn. During signal integration the input is connected to the integrator for a fixed number of counts. During reference integration a reference of opposing sign is connected until the integrator returns to zero. During auto-zero the input is isolated and the offset-storage loop is closed. Auto-zero takes up whatever part of the cycle the reference phase left unused.

The only analog observation is a comparator bit that tells on which side of zero the integrator output lies. Its value at the end of signal integration gives the input sign. That sign sets which reference polarity is switched in, and the reference phase ends when the comparator leaves that side. The number of whole counts spent in reference integration is the reading. The block keeps it as four BCD decades, so a display decoder can use it without conversion. When the phase ends it latches the reading with a sign flag and an overrange flag, and pulses a valid strobe for one clock.

All timing figures below use the default parameters: PRESCALE=4, SIG_COUNTS=1000, REF_MAX=2000, CYCLE_COUNTS=4000, DIGITS=4.

Top module: `dsadc_sequencer`

## Requirements
- R1: A count tick occurs once every PRESCALE clocks. Every phase boundary falls on a tick, so each phase enable stays high for a whole multiple of PRESCALE clocks.
- R2: The signal phase (sig_en high) lasts exactly SIG_COUNTS counts, which is SIG_COUNTS*PRESCALE clocks.
- R3: Each measurement cycle is CYCLE_COUNTS counts long whatever the input, so successive rising edges of sig_en are always CYCLE_COUNTS*PRESCALE clocks apart.
- R4: The input sign is the value of cmp_hi at the last tick of the signal phase. Changes to cmp_hi earlier in that phase have no effect. For the whole reference phase, ref_minus equals that sampled value (1 selects the negative reference), and the result carries res_neg = NOT of it.
- R5: At each tick of the reference phase, the block first tests whether cmp_hi differs from the sampled sign. If it does, the phase ends and the reading is the number of counts already completed in that phase. In that case ref_en stays high for (reading+1)*PRESCALE clocks.
- R6: If no crossing is seen before the count reaches REF_MAX, the phase ends with reading REF_MAX and res_ovr=1, and ref_en stays high for REF_MAX*PRESCALE clocks. A crossing seen at that same tick takes priority and gives REF_MAX-1 with res_ovr=0.
- R7: Exactly one of az_en, sig_en and ref_en is high in every cycle. Auto-zero fills the rest of the cycle, so it is never shorter than CYCLE_COUNTS-SIG_COUNTS-REF_MAX counts.
- R8: res_bcd holds the reading as BCD. Bits [3:0] are units, [7:4] tens, [11:8] hundreds and [15:12] thousands, and each digit stays within 0..9.
- R9: res_valid is high for exactly one clock, in the clock after the edge at which ref_en falls. res_bcd, res_neg and res_ovr change only together with that pulse.
- R10: While rst_n is low and just after it is released: az_en=1, sig_en=0, ref_en=0, res_valid=0, res_bcd=0, res_neg=0, res_ovr=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_hi | input | 1 | Integrator comparator, 1 = output above zero |
| az_en | output | 1 | Auto-zero switches closed, input isolated |
| sig_en | output | 1 | Input connected to the integrator |
| ref_en | output | 1 | Reference connected to the integrator |
| ref_minus | output | 1 | Reference polarity, 1 = negative reference |
| res_valid | output | 1 | One-clock strobe for a new result |
| res_neg | output | 1 | Result sign, 1 = negative input |
| res_ovr | output | 1 | Result overrange flag |
| res_bcd | output | 4*DIGITS | Result digits in BCD, units in the low nibble |

## Verification
The bench times every phase enable in clocks against the tick arithmetic. A design that counts clocks instead of ticks, or that lets reference time stretch the cycle, would shift the spacing of sig_en edges. The bench moves the comparator on purpose at and around the decisive ticks: zero readings, readings that end one tick before the overrange limit, and inputs that never cross. An off-by-one in crossing detection, or overrange taking priority over a late crossing, would give a wrong count or flag. One test holds the comparator at the wrong sign for part of the signal phase. A design that samples the sign early, or keeps following the comparator, would pick the wrong reference polarity and sign.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_SIG = 2'd1,
    PH_REF = 2'd2
  } phase_t;

  // Binary to eight BCD digits, units in the low nibble
  function automatic logic [31:0] int_to_bcd(input int unsigned v);
    logic [31:0] r;
    int unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < 8; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int unsigned bcd_to_int(input logic [31:0] b);
    int unsigned acc;
    acc = 0;
    for (int i = 7; i >= 0; i--) begin
      acc = acc * 10 + {28'd0, b[i*4 +: 4]};
    end
    return acc;
  endfunction

endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);

  generate
    if (PRESCALE > 1) begin : g_spacing
      // R1: ticks never come on consecutive clocks
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  inc,
  output logic [DIGITS*4-1:0]   value
);
  logic [DIGITS:0] carry;
  assign carry[0] = inc;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      logic [3:0] d;
      logic       wrap;
      assign wrap         = (d == 4'd9);
      assign carry[g+1]   = carry[g] && wrap;
      assign value[g*4 +: 4] = d;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        d <= '0;
        else if (clr)      d <= '0;
        else if (carry[g]) d <= wrap ? 4'd0 : d + 4'd1;
      end

      assert_digit_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        d <= 4'd9);
    end
  endgenerate

  // R6: the reference window ends before the top decade can roll over
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !carry[DIGITS]);

endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int SIG_COUNTS   = 1000,
  parameter int REF_MAX      = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                cmp_hi,
  input  logic [DIGITS*4-1:0] ref_count,
  output phase_t              phase,
  output logic                pol_pos,
  output logic                sig_done,
  output logic                ref_stop_cross,
  output logic                ref_stop_ovr
);
  localparam int PW = $clog2(CYCLE_COUNTS);
  localparam logic [PW-1:0] POS_SIG_LAST = PW'(SIG_COUNTS - 1);
  localparam logic [PW-1:0] POS_CYC_LAST = PW'(CYCLE_COUNTS - 1);
  localparam logic [PW-1:0] POS_RESET    = PW'(SIG_COUNTS + REF_MAX);
  localparam logic [PW-1:0] POS_REF_LAST = PW'(SIG_COUNTS + REF_MAX - 1);
  localparam logic [31:0]   LAST32       = int_to_bcd(REF_MAX - 1);
  localparam logic [DIGITS*4-1:0] LAST_BCD = LAST32[DIGITS*4-1:0];

  logic [PW-1:0] pos;
  logic          crossed;
  logic          at_last;
  logic          az_done;
  phase_t        phase_nx;

  assign crossed        = (cmp_hi != pol_pos);
  assign at_last        = (ref_count == LAST_BCD);
  assign sig_done       = tick && (phase == PH_SIG) && (pos == POS_SIG_LAST);
  assign ref_stop_cross = tick && (phase == PH_REF) && crossed;
  assign ref_stop_ovr   = tick && (phase == PH_REF) && !crossed && at_last;
  assign az_done        = tick && (phase == PH_AZ) && (pos == POS_CYC_LAST);

  always_comb begin
    phase_nx = phase;
    if (sig_done)                            phase_nx = PH_REF;
    else if (ref_stop_cross || ref_stop_ovr) phase_nx = PH_AZ;
    else if (az_done)                        phase_nx = PH_SIG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_AZ;
      pos     <= POS_RESET;
      pol_pos <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (tick) pos <= (pos == POS_CYC_LAST) ? '0 : pos + PW'(1);
      if (sig_done) pol_pos <= cmp_hi;
    end
  end

  // R3: every signal phase starts at cycle position zero
  assert_sig_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SIG && $past(phase) != PH_SIG) |-> pos == '0);
  // R6: reference phase never runs past its window
  assert_ref_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REF) |-> (pos > POS_SIG_LAST && pos <= POS_REF_LAST));
  // R4: captured sign is frozen through the reference phase
  assert_pol_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REF && $past(phase) == PH_REF) |-> $stable(pol_pos));
  // R7: auto-zero only occupies positions after the signal window
  assert_az_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AZ) |-> pos > POS_SIG_LAST);

endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int PRESCALE     = 4,
  parameter int SIG_COUNTS   = 1000,
  parameter int REF_MAX      = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_hi,
  output logic                az_en,
  output logic                sig_en,
  output logic                ref_en,
  output logic                ref_minus,
  output logic                res_valid,
  output logic                res_neg,
  output logic                res_ovr,
  output logic [DIGITS*4-1:0] res_bcd
);
  localparam int BW = DIGITS * 4;
  localparam logic [31:0]   MAX32   = int_to_bcd(REF_MAX);
  localparam logic [BW-1:0] MAX_BCD = MAX32[BW-1:0];

  logic          tick;
  phase_t        phase;
  logic          pol_pos;
  logic          sig_done;
  logic          ref_stop_cross;
  logic          ref_stop_ovr;
  logic          cnt_inc;
  logic [BW-1:0] ref_count;

  dsadc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign cnt_inc = tick && (phase == PH_REF) && !ref_stop_cross;

  dsadc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sig_done), .inc(cnt_inc), .value(ref_count)
  );

  dsadc_phase_ctrl #(
    .SIG_COUNTS(SIG_COUNTS), .REF_MAX(REF_MAX),
    .CYCLE_COUNTS(CYCLE_COUNTS), .DIGITS(DIGITS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_hi(cmp_hi),
    .ref_count(ref_count), .phase(phase), .pol_pos(pol_pos),
    .sig_done(sig_done), .ref_stop_cross(ref_stop_cross),
    .ref_stop_ovr(ref_stop_ovr)
  );

  assign az_en     = (phase == PH_AZ);
  assign sig_en    = (phase == PH_SIG);
  assign ref_en    = (phase == PH_REF);
  assign ref_minus = pol_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_neg   <= 1'b0;
      res_ovr   <= 1'b0;
      res_bcd   <= '0;
    end else begin
      res_valid <= ref_stop_cross || ref_stop_ovr;
      if (ref_stop_cross) begin
        res_bcd <= ref_count;
        res_ovr <= 1'b0;
        res_neg <= !pol_pos;
      end else if (ref_stop_ovr) begin
        res_bcd <= MAX_BCD;
        res_ovr <= 1'b1;
        res_neg <= !pol_pos;
      end
    end
  end

  assert_onehot_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({az_en, sig_en, ref_en}));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({res_bcd, res_neg, res_ovr}));
  // R5: a result follows every end of the reference phase
  assert_valid_on_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_en) && !ref_en) |-> res_valid);
  assert_ovr_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovr) |-> res_bcd == MAX_BCD);

endmodule

// File: tb/tb_dsadc_sequencer.sv
`timescale 1ns/1ps
module tb_dsadc_sequencer;
  localparam int P   = 4;
  localparam int SIG = 100;
  localparam int RMX = 200;
  localparam int CYC = 400;
  localparam int DG  = 4;
  localparam int NV  = 8;
  // {reading target, negative input}
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{1, 1}, '{9, 0}, '{10, 1},
    '{57, 0}, '{100, 1}, '{199, 0}, '{150, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_hi = 1'b0;
  logic az_en, sig_en, ref_en, ref_minus, res_valid, res_neg, res_ovr;
  logic [DG*4-1:0] res_bcd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsadc_sequencer #(
    .PRESCALE(P), .SIG_COUNTS(SIG), .REF_MAX(RMX),
    .CYCLE_COUNTS(CYC), .DIGITS(DG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi),
    .az_en(az_en), .sig_en(sig_en), .ref_en(ref_en), .ref_minus(ref_minus),
    .res_valid(res_valid), .res_neg(res_neg), .res_ovr(res_ovr),
    .res_bcd(res_bcd)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return 16'(((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
               ((v / 10) % 10) * 16 + (v % 10));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Phase timing monitor (R1, R2, R3)
  bit prev_sig = 1'b0;
  bit seen_rise = 1'b0;
  int since_rise = 0;
  int sig_len = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      since_rise++;
      if (sig_en) sig_len++;
      if (sig_en && !prev_sig) begin
        if (seen_rise)
          check(since_rise == CYC*P, "R3", "sig_en rise spacing", since_rise, CYC*P);
        seen_rise = 1'b1;
        since_rise = 0;
      end
      if (!sig_en && prev_sig) begin
        check(sig_len == SIG*P, "R2", "sig_en length", sig_len, SIG*P);
        check(sig_len % P == 0, "R1", "sig_en length multiple of prescale", sig_len % P, 0);
        sig_len = 0;
      end
      prev_sig = sig_en;
    end
  end

  task automatic run_conv(input int target, input bit neg, input bit early_wrong);
    int n;
    int exp_clk;
    bit ovr;
    ovr = (target >= RMX);
    exp_clk = ovr ? RMX*P : (target + 1)*P;
    while (!sig_en) @(negedge clk);
    if (early_wrong) begin
      cmp_hi = neg;
      repeat (20) @(negedge clk);
    end
    cmp_hi = !neg;
    while (!ref_en) @(negedge clk);
    check(ref_minus == !neg, "R4", "ref_minus polarity", ref_minus, !neg);
    n = 0;
    while (ref_en) begin
      n++;
      if (n >= target*P + 1) cmp_hi = neg;
      @(negedge clk);
    end
    check(n == exp_clk, ovr ? "R6" : "R5", "ref_en clocks", n, exp_clk);
    check(res_valid == 1'b1, "R9", "valid after ref exit", res_valid, 1);
    check(res_bcd == (ovr ? to_bcd(RMX) : to_bcd(target)), "R8",
          "bcd reading", res_bcd, ovr ? to_bcd(RMX) : to_bcd(target));
    check(res_ovr == ovr, "R6", "overrange flag", res_ovr, ovr);
    check(res_neg == neg, "R4", "sign flag", res_neg, neg);
    @(negedge clk);
    check(res_valid == 1'b0, "R9", "valid single clock", res_valid, 0);
    check(res_bcd == (ovr ? to_bcd(RMX) : to_bcd(target)), "R9",
          "result held", res_bcd, ovr ? to_bcd(RMX) : to_bcd(target));
    check(az_en == 1'b1, "R7", "auto-zero after ref", az_en, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(az_en == 1'b1, "R10", "az_en in reset", az_en, 1);
    check(sig_en == 1'b0 && ref_en == 1'b0, "R10", "sig/ref in reset", {sig_en, ref_en}, 0);
    check(res_valid == 1'b0, "R10", "valid in reset", res_valid, 0);
    check(res_bcd == '0 && !res_neg && !res_ovr, "R10", "result in reset",
          {res_neg, res_ovr, res_bcd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(az_en == 1'b1, "R10", "az_en after release", az_en, 1);

    for (int i = 0; i < NV; i++) run_conv(VEC[i][0], VEC[i][1] != 0, 1'b0);

    run_conv(RMX, 1'b0, 1'b0);      // R6 overrange, positive
    run_conv(RMX + 37, 1'b1, 1'b0); // R6 overrange, negative
    run_conv(42, 1'b1, 1'b1);       // R4 early wrong sign ignored
    run_conv(RMX - 1, 1'b1, 1'b0);  // R6 crossing wins at last tick
    run_conv(0, 1'b0, 1'b1);        // R5 zero reading after sign change

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule